// File: doc/BRIEF.md
# I/O-Mapped Microsecond Countdown Timer

This block is a 16-bit countdown timer that software reaches through a small, relocatable window of four I/O ports. Two configuration bytes form the 16-bit window base address. Bit 0 of that base turns decoding on or off, and the two lowest address bits are masked off to align the window. Inside the window, the first two ports carry the low and high halves of the timer. The other two ports do not respond.

Software programs a 16-bit reload value one byte at a time or as a whole word. Each accepted write copies the updated reload value into the down-counter, which then counts one unit per microsecond tick pulse and stops at zero. A read returns the count that is left, as one byte or as a full word. The read path is combinational from the counter register, so a read returns the value held at the start of its cycle.

Top module: `io_usec_timer`

## Requirements
- R1: After reset the low base byte is 0x78 and the high base byte is 0x00, so decoding is disabled. The reload value and the count are both zero.
- R2: A configuration write with `cfg_sel`=0 stores `cfg_wdata` into the low base byte with bit 1 forced to 0. With `cfg_sel`=1 it stores `cfg_wdata` unchanged into the high base byte.
- R3: The window is the four addresses from {high byte, low byte[7:2], 2'b00} up to that value plus 3. It decodes only while bit 0 of the low base byte is 1.
- R4: Inside the window, addresses with bit 1 set return 0xFFFF on reads, and writes to them change neither the reload value nor the count.
- R5: A byte write (`io_word`=0) with address bit 0 clear replaces reload bits [7:0] with `io_wdata[7:0]`. With address bit 0 set it replaces bits [15:8] with `io_wdata[7:0]`. A word write (`io_word`=1) replaces all 16 bits with `io_wdata`.
- R6: Every accepted write loads the count with the new reload value at the clock edge that ends the write cycle.
- R7: In a cycle with `usec_tick` high and no accepted write, a nonzero count drops by one. A zero count stays at zero.
- R8: A byte read returns the addressed half of the current count in `io_rdata[7:0]`, with 0xFF in `io_rdata[15:8]`. A word read returns the full count. The value is the one present before any decrement in the same cycle.
- R9: An access outside the enabled window changes neither the reload value nor the count, and a read there returns 0xFFFF.
- R10: A base change made by a configuration write applies to bus accesses from the next cycle onward.
- R11: When an accepted write and a tick fall in the same cycle, the load wins and the count equals the new reload value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_sel | input | 1 | 0 selects the low base byte, 1 the high base byte |
| cfg_wdata | input | 8 | Configuration write data |
| io_addr | input | 16 | I/O bus address |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_word | input | 1 | 1 for a 16-bit access, 0 for a byte access |
| io_wdata | input | 16 | I/O write data (byte writes use bits 7:0) |
| usec_tick | input | 1 | One-cycle pulse per microsecond |
| io_rdata | output | 16 | I/O read data |

## Verification
The hardest case to reach is the boundary between adjacent windows. This includes the neighbouring four-port block, windows that sit on a relocated base with bit 1 of the written value set, and bases at the top of the address space. The stimulus steps the low base byte through all 64 aligned positions under several high bytes. At each position it writes a value through the window, then probes the dead ports and the ports just outside it. A second difficult corner is the coincidence of a tick with a read or a write. The bench drives those in the same cycle on purpose, after loading small counts so that expiry and hold at zero come within a few ticks.

// File: rtl/io_tmr_pkg.sv
package io_tmr_pkg;
    localparam int unsigned ADDR_W = 16;
    localparam int unsigned CNT_W  = 16;
    localparam int unsigned WIN_LSB = 2;

    typedef struct packed {
        logic [7:0] lo;
        logic [7:0] hi;
    } base_regs_t;

    typedef struct packed {
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;
endpackage

// File: rtl/io_tmr_cfg.sv
module io_tmr_cfg
    import io_tmr_pkg::*;
#(
    parameter logic [7:0] RST_LO = 8'h78,
    parameter logic [7:0] RST_HI = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic       cfg_sel,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] base_lo,
    output logic [7:0] base_hi
);
    base_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (cfg_we) begin
            if (cfg_sel) regs_d.hi = cfg_wdata;
            else         regs_d.lo = cfg_wdata & 8'hFD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.lo <= RST_LO & 8'hFD;
            regs_q.hi <= RST_HI;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign base_lo = regs_q.lo;
    assign base_hi = regs_q.hi;
endmodule

// File: rtl/io_tmr_decode.sv
module io_tmr_decode
    import io_tmr_pkg::*;
(
    input  logic [7:0]        base_lo,
    input  logic [7:0]        base_hi,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              port_ok,
    output logic              hi_half
);
    logic              win_hit;
    logic              unused_bit1;
    logic [ADDR_W-1:0] win_base;

    assign unused_bit1 = base_lo[1];
    assign win_base    = {base_hi, base_lo[7:WIN_LSB], {WIN_LSB{1'b0}}};

    always_comb begin
        win_hit = base_lo[0] && (io_addr[ADDR_W-1:WIN_LSB] == win_base[ADDR_W-1:WIN_LSB]);
        port_ok = win_hit && !io_addr[1];
        hi_half = io_addr[0];
    end
endmodule

// File: rtl/io_tmr_core.sv
module io_tmr_core
    import io_tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_word,
    input  logic             wr_hi,
    input  logic [CNT_W-1:0] wdata,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] reload
);
    tmr_state_t st_d, st_q;
    logic [CNT_W-1:0] merged;

    always_comb begin
        st_d   = st_q;
        merged = st_q.reload;
        if (wr_word)    merged = wdata;
        else if (wr_hi) merged[15:8] = wdata[7:0];
        else            merged[7:0]  = wdata[7:0];

        if (wr_en) begin
            st_d.reload = merged;
            st_d.cnt    = merged;
        end else if (tick && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt    = st_q.cnt;
    assign reload = st_q.reload;
endmodule

// File: rtl/io_usec_timer.sv
module io_usec_timer
    import io_tmr_pkg::*;
#(
    parameter logic [7:0] RST_LO = 8'h78,
    parameter logic [7:0] RST_HI = 8'h00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic        cfg_sel,
    input  logic [7:0]  cfg_wdata,
    input  logic [15:0] io_addr,
    input  logic        io_rd,
    input  logic        io_wr,
    input  logic        io_word,
    input  logic [15:0] io_wdata,
    input  logic        usec_tick,
    output logic [15:0] io_rdata
);
    logic [7:0]       base_lo_q;
    logic [7:0]       base_hi_q;
    logic             port_ok;
    logic             hi_half;
    logic             wr_acc;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_q;

    io_tmr_cfg #(.RST_LO(RST_LO), .RST_HI(RST_HI)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .base_lo   (base_lo_q),
        .base_hi   (base_hi_q)
    );

    io_tmr_decode u_dec (
        .base_lo (base_lo_q),
        .base_hi (base_hi_q),
        .io_addr (io_addr),
        .port_ok (port_ok),
        .hi_half (hi_half)
    );

    assign wr_acc = io_wr && port_ok;

    io_tmr_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_acc),
        .wr_word (io_word),
        .wr_hi   (hi_half),
        .wdata   (io_wdata),
        .tick    (usec_tick),
        .cnt     (cnt_q),
        .reload  (reload_q)
    );

    always_comb begin
        io_rdata = 16'hFFFF;
        if (io_rd && port_ok) begin
            if (io_word)      io_rdata = cnt_q;
            else if (hi_half) io_rdata = {8'hFF, cnt_q[15:8]};
            else              io_rdata = {8'hFF, cnt_q[7:0]};
        end
    end
endmodule

// File: rtl/io_tmr_checker.sv
module io_tmr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        io_rd,
    input logic        io_word,
    input logic        usec_tick,
    input logic        wr_acc,
    input logic        port_ok,
    input logic [15:0] io_addr,
    input logic [15:0] io_rdata,
    input logic [7:0]  base_lo_q,
    input logic [7:0]  base_hi_q,
    input logic [15:0] cnt_q,
    input logic [15:0] reload_q
);
    logic in_dead_port;
    assign in_dead_port = base_lo_q[0] && io_addr[1]
                       && (io_addr[15:2] == {base_hi_q, base_lo_q[7:2]});

    assert_base_bit1_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        base_lo_q[1] == 1'b0);

    assert_dead_port_reads_ff_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && in_dead_port) |-> (io_rdata == 16'hFFFF));

    assert_load_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |=> (cnt_q == reload_q));

    assert_tick_decrement_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_acc && usec_tick && cnt_q != 16'd0) |=> (cnt_q == $past(cnt_q) - 16'd1));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_acc && cnt_q == 16'd0) |=> (cnt_q == 16'd0));

    assert_byte_read_pad_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && port_ok && !io_word) |-> (io_rdata[15:8] == 8'hFF));

    assert_reload_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_acc |=> $stable(reload_q));
endmodule

bind io_usec_timer io_tmr_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_rd     (io_rd),
    .io_word   (io_word),
    .usec_tick (usec_tick),
    .wr_acc    (wr_acc),
    .port_ok   (port_ok),
    .io_addr   (io_addr),
    .io_rdata  (io_rdata),
    .base_lo_q (base_lo_q),
    .base_hi_q (base_hi_q),
    .cnt_q     (cnt_q),
    .reload_q  (reload_q)
);

// File: tb/tb_io_usec_timer.sv
module tb_io_usec_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic        io_word = 1'b0;
    logic [15:0] io_wdata = '0;
    logic        usec_tick = 1'b0;
    logic [15:0] io_rdata;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] exp_reload = '0;
    logic [15:0] exp_cnt = '0;
    logic [15:0] base = 16'h0078;

    always #(CLK_PERIOD/2) clk = ~clk;

    io_usec_timer dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_word(io_word), .io_wdata(io_wdata), .usec_tick(usec_tick),
        .io_rdata(io_rdata)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic set_base(input logic [7:0] hi, input logic [7:0] lo);
        cfg_write(1'b1, hi);
        cfg_write(1'b0, lo);
    endtask

    task automatic bus_write(input logic [15:0] a, input logic w, input logic [15:0] d,
                             input logic tk);
        @(negedge clk);
        io_addr = a; io_wr = 1'b1; io_word = w; io_wdata = d; usec_tick = tk;
        @(posedge clk); #1;
        io_wr = 1'b0; usec_tick = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, input logic w, input logic tk,
                            output logic [15:0] v);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1; io_word = w; usec_tick = tk;
        #1 v = io_rdata;
        @(posedge clk); #1;
        io_rd = 1'b0; usec_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        usec_tick = 1'b1;
        repeat (n) @(posedge clk);
        #1 usec_tick = 1'b0;
    endtask

    function automatic logic [15:0] sat_sub(input logic [15:0] c, input int n);
        return (int'(c) > n) ? c - 16'(n) : 16'd0;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset base 0x0078 with decode off -> reads 0xFFFF, write ignored
        bus_read(16'h0078, 1'b1, 1'b0, v);
        check("R1 decode off after reset", v, 16'hFFFF);
        bus_write(16'h0078, 1'b1, 16'h1234, 1'b0);
        cfg_write(1'b0, 8'h79);
        // R10: enable applies next cycle; R1: count still zero
        bus_read(16'h0078, 1'b1, 1'b0, v);
        check("R1 count zero after reset", v, 16'h0000);

        // R5/R6: byte writes replace halves and reload the count
        bus_write(16'h0078, 1'b0, 16'hAB34, 1'b0); exp_reload = 16'h0034; exp_cnt = exp_reload;
        bus_read(16'h0078, 1'b1, 1'b0, v);
        check("R5 low byte write", v, exp_cnt);
        bus_write(16'h0079, 1'b0, 16'hCD12, 1'b0); exp_reload = 16'h1234; exp_cnt = exp_reload;
        bus_read(16'h0078, 1'b1, 1'b0, v);
        check("R6 high byte write reloads", v, exp_cnt);
        // R8: byte reads
        bus_read(16'h0078, 1'b0, 1'b0, v);
        check("R8 low byte read", v, 16'hFF34);
        bus_read(16'h0079, 1'b0, 1'b0, v);
        check("R8 high byte read", v, 16'hFF12);
        // R4: dead ports
        bus_read(16'h007A, 1'b1, 1'b0, v);
        check("R4 offset 2 read", v, 16'hFFFF);
        bus_read(16'h007B, 1'b0, 1'b0, v);
        check("R4 offset 3 read", v, 16'hFFFF);
        bus_write(16'h007A, 1'b1, 16'h5555, 1'b0);
        bus_write(16'h007B, 1'b0, 16'h0066, 1'b0);
        bus_read(16'h0078, 1'b1, 1'b0, v);
        check("R4 dead port writes ignored", v, exp_cnt);

        // R7: countdown and hold at zero
        bus_write(16'h0078, 1'b1, 16'd5, 1'b0); exp_reload = 16'd5; exp_cnt = 16'd5;
        ticks(3); exp_cnt = sat_sub(exp_cnt, 3);
        bus_read(16'h0078, 1'b1, 1'b0, v);
        check("R7 decrement per tick", v, exp_cnt);
        ticks(6); exp_cnt = sat_sub(exp_cnt, 6);
        bus_read(16'h0078, 1'b1, 1'b0, v);
        check("R7 hold at zero", v, exp_cnt);

        // R8: read in a tick cycle shows pre-decrement value
        bus_write(16'h0078, 1'b1, 16'h0100, 1'b0); exp_reload = 16'h0100; exp_cnt = exp_reload;
        bus_read(16'h0078, 1'b1, 1'b1, v);
        check("R8 read during tick", v, 16'h0100);
        exp_cnt = 16'h00FF;
        bus_read(16'h0078, 1'b0, 1'b1, v);
        check("R8 byte read during tick", v, 16'hFFFF);
        exp_cnt = 16'h00FE;
        bus_read(16'h0079, 1'b0, 1'b0, v);
        check("R7 borrow across bytes", v, 16'hFF00);

        // R11: write and tick together
        bus_write(16'h0078, 1'b1, 16'h0042, 1'b1); exp_reload = 16'h0042; exp_cnt = exp_reload;
        bus_read(16'h0078, 1'b1, 1'b0, v);
        check("R11 load wins over tick", v, exp_cnt);
        // R6: partial write reloads from merged reload, not from count
        ticks(2); exp_cnt = sat_sub(exp_cnt, 2);
        bus_write(16'h0079, 1'b0, 16'h0007, 1'b0); exp_reload = 16'h0742; exp_cnt = exp_reload;
        bus_read(16'h0078, 1'b1, 1'b0, v);
        check("R6 byte write reloads merged value", v, exp_cnt);

        // R2/R3/R9/R10: relocation sweep over all aligned low bytes
        foreach (base[i]) begin end
        for (int h = 0; h < 3; h++) begin
            logic [7:0] hb;
            hb = (h == 0) ? 8'h00 : (h == 1) ? 8'h5A : 8'hFF;
            for (int l = 0; l < 64; l++) begin
                logic [15:0] old_base, wv;
                old_base = base;
                base = {hb, 6'(l), 2'b00};
                set_base(hb, {6'(l), 2'b11});
                wv = {hb, 2'b10, 6'(l)} ^ 16'h3C00;
                bus_write(base, 1'b1, wv, 1'b0); exp_reload = wv; exp_cnt = wv;
                bus_read(base, 1'b1, 1'b0, v);
                check("R3 relocated window word", v, exp_cnt);
                bus_read(base + 16'd2, 1'b1, 1'b0, v);
                check("R2 bit1 forced clear", v, 16'hFFFF);
                bus_write(base + 16'd4, 1'b1, ~wv, 1'b0);
                bus_write(base - 16'd4, 1'b0, ~wv, 1'b0);
                bus_read(base + 16'd4, 1'b1, 1'b0, v);
                check("R9 outside read", v, 16'hFFFF);
                if (old_base != base) begin
                    bus_read(old_base, 1'b1, 1'b0, v);
                    check("R10 old window gone", v, 16'hFFFF);
                end
                bus_read(base + 16'd1, 1'b0, 1'b0, v);
                check("R9 outside writes ignored", v, {8'hFF, exp_cnt[15:8]});
            end
        end

        // R3: clearing the enable bit stops decode
        cfg_write(1'b0, base[7:0]);
        bus_read(base, 1'b1, 1'b0, v);
        check("R3 enable cleared", v, 16'hFFFF);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule